// File: doc/BRIEF.md
# Serial Command Frame Decoder

This block is a slave on a three-line synchronous serial command bus. Each transaction carries three 16-bit words side by side. The frame line carries the frame word MSB first, and its leading 1 is the start bit. The address line carries the address word MSB first. The data line carries the data word LSB first. After the sixteenth bit, the block compares the frame's chip field with a strap input and decodes its 4-bit register-space selector. It then issues a single-cycle write strobe, read request or init pulse together with the captured address and data.

Reads are answered on a return pair: the returned frame line is held high for 16 cycles while the read word is shifted out LSB first. Read words come from a small internal status/mode/version space. For the other readable spaces they come from a read-data input sampled in the request cycle.

The controller has four states. IDLE waits for a start bit (IDLE→SHIFT when the frame line is 1). SHIFT takes the remaining 15 bits (SHIFT→ISSUE after the sixteenth). ISSUE lasts one cycle and drives the strobes (ISSUE→REPLY for a read, ISSUE→IDLE otherwise). REPLY sends the answer (REPLY→IDLE once 16 bits are out). The serial inputs are ignored outside IDLE and SHIFT.

Top module: `sercmd_decoder`

## Requirements
- R1: After reset all strobes, `file_sel`, `reg_addr`, `reg_wdata`, `ser_frm_o`, `ser_dat_o` and `mode_o` are 0.
- R2: A transaction starts when IDLE sees `ser_frm_i`=1. From that cycle on, 16 consecutive bits are taken: frame and address MSB first, data LSB first (the first data bit becomes `reg_wdata[0]`).
- R3: A write strobe lasts exactly one cycle, the cycle after the sixteenth bit is sampled. It occurs for selector 0, 1, 2, 6, 9, 10, 11, 12, and for selector 3 with address 1. In that cycle `file_sel` equals frame bits 10..7, `reg_addr` the address word and `reg_wdata` the data word. At most one of the three strobes is high.
- R4: A frame whose bits 14..11 differ from `chip_strap` produces no strobe, no pulse and no reply.
- R5: Selectors 13, 14 and 15 produce no activity, and so does selector 3 with an address other than 0, 1 or 2. Frame bits 6..0 have no effect.
- R6: Selector 5 produces a one-cycle `pll_init` pulse in the strobe cycle and no write strobe.
- R7: A write to selector 3, address 1 loads `mode_o` from data bit 0 (0 = filter path, 1 = test memory). No other frame changes `mode_o`.
- R8: Selector 3 address 0 reads the status word: bits 2..0 parity errors, 5..3 sync errors, 8..6 bunch-crossing errors, 9 lock error, 10 `mode_o`, 13..11 zero, 14 alignment error, 15 locked. Address 2 reads the `VERSION` parameter.
- R9: Selectors 4, 7 and 8 give a one-cycle `rd_req`, and `rd_data_i` is sampled in that cycle.
- R10: In the cycle after any read request, `ser_frm_o` rises and stays high for exactly 16 cycles while `ser_dat_o` presents the read word LSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_frm_i | input | 1 | Serial frame line, MSB first |
| ser_adr_i | input | 1 | Serial address line, MSB first |
| ser_dat_i | input | 1 | Serial data line, LSB first |
| chip_strap | input | 4 | This chip's bus address |
| rd_data_i | input | 16 | Read word for selectors 4, 7, 8 |
| par_err_i | input | 3 | Per-cable parity error flags |
| sync_err_i | input | 3 | Per-cable sync error flags |
| bx_err_i | input | 3 | Per-cable bunch-crossing error flags |
| lock_err_i | input | 1 | Clock lock error flag |
| align_err_i | input | 1 | Sync alignment error flag |
| locked_i | input | 1 | Clock locked flag |
| wr_stb | output | 1 | One-cycle write strobe |
| rd_req | output | 1 | One-cycle read request |
| pll_init | output | 1 | One-cycle init pulse |
| file_sel | output | 4 | Captured register-space selector |
| reg_addr | output | 16 | Captured address word |
| reg_wdata | output | 16 | Captured data word |
| mode_o | output | 1 | Mode flag |
| ser_frm_o | output | 1 | Returned frame line |
| ser_dat_o | output | 1 | Returned serial data, LSB first |

## Verification
The bench sweeps all sixteen selectors with a matching chip field. Address, data and the ignored low frame bits change with each selector, so an address or data word taken in the wrong bit order shows up as a wrong `reg_addr` or `reg_wdata`. The same sweep catches a selector decoded from the wrong bits, because a wrong class of strobe appears. All fifteen non-matching chip fields are sent to catch a design that fails to filter by address. Replies are collected over 17 cycles, so an off-by-one in the 16-cycle return frame or a reversed bit order fails the comparison. Status reads are repeated under several error-flag patterns and both mode values, which exposes a misplaced status bit or a mode write that does not take effect.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_ISSUE,
        ST_REPLY
    } sercmd_state_e;

    localparam int FRAME_START_BIT = 15;
    localparam int CHIP_HI = 14;
    localparam int CHIP_LO = 11;
    localparam int SEL_HI  = 10;
    localparam int SEL_LO  = 7;

    localparam logic [3:0] SEL_LOCAL = 4'd3;
    localparam logic [3:0] SEL_INIT  = 4'd5;

    typedef struct packed {
        logic wr;
        logic rd;
        logic pll;
        logic local_rd;
    } sercmd_op_t;
endpackage

// File: rtl/sercmd_capture.sv
module sercmd_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         frm_bit,
    input  logic         adr_bit,
    input  logic         dat_bit,
    output logic [W-1:0] frame_w,
    output logic [W-1:0] addr_w,
    output logic [W-1:0] data_w
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_w <= '0;
            addr_w  <= '0;
            data_w  <= '0;
        end else if (shift_en) begin
            frame_w <= {frame_w[W-2:0], frm_bit};
            addr_w  <= {addr_w[W-2:0], adr_bit};
            data_w  <= {dat_bit, data_w[W-1:1]};
        end
    end
endmodule

// File: rtl/sercmd_decode.sv
module sercmd_decode
    import sercmd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] frame_w,
    input  logic [W-1:0] addr_w,
    input  logic [3:0]   chip_strap,
    output sercmd_op_t   op
);
    logic       hit;
    logic [3:0] sel;

    always_comb begin
        hit = frame_w[FRAME_START_BIT] && (frame_w[CHIP_HI:CHIP_LO] == chip_strap);
        sel = frame_w[SEL_HI:SEL_LO];
        op  = '0;
        if (hit) begin
            unique case (sel)
                4'd0, 4'd1, 4'd2, 4'd6,
                4'd9, 4'd10, 4'd11, 4'd12: op.wr = 1'b1;
                4'd4, 4'd7, 4'd8:          op.rd = 1'b1;
                SEL_INIT:                  op.pll = 1'b1;
                SEL_LOCAL: begin
                    if (addr_w == W'(1)) begin
                        op.wr = 1'b1;
                    end else if (addr_w == W'(0) || addr_w == W'(2)) begin
                        op.rd       = 1'b1;
                        op.local_rd = 1'b1;
                    end
                end
                default: op = '0;
            endcase
        end
    end
endmodule

// File: rtl/sercmd_reply.sv
module sercmd_reply #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] word,
    output logic         frm_o,
    output logic         dat_o,
    output logic         done
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  sr;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr    <= '0;
            cnt   <= '0;
            frm_o <= 1'b0;
        end else if (load) begin
            sr    <= word;
            cnt   <= '0;
            frm_o <= 1'b1;
        end else if (frm_o) begin
            sr  <= {1'b0, sr[W-1:1]};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(W-1)) begin
                frm_o <= 1'b0;
            end
        end
    end

    assign dat_o = frm_o & sr[0];
    assign done  = frm_o && (cnt == CW'(W-1));
endmodule

// File: rtl/sercmd_decoder.sv
module sercmd_decoder
    import sercmd_pkg::*;
#(
    parameter int          W       = 16,
    parameter logic [15:0] VERSION = 16'h0102
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_frm_i,
    input  logic        ser_adr_i,
    input  logic        ser_dat_i,
    input  logic [3:0]  chip_strap,
    input  logic [15:0] rd_data_i,
    input  logic [2:0]  par_err_i,
    input  logic [2:0]  sync_err_i,
    input  logic [2:0]  bx_err_i,
    input  logic        lock_err_i,
    input  logic        align_err_i,
    input  logic        locked_i,
    output logic        wr_stb,
    output logic        rd_req,
    output logic        pll_init,
    output logic [3:0]  file_sel,
    output logic [15:0] reg_addr,
    output logic [15:0] reg_wdata,
    output logic        mode_o,
    output logic        ser_frm_o,
    output logic        ser_dat_o
);
    localparam int CW = $clog2(W);

    sercmd_state_e state, nxt;
    logic [CW-1:0] bit_cnt;
    logic          shift_en;
    logic [W-1:0]  frame_w, addr_w, data_w;
    sercmd_op_t    op;
    logic          issue;
    logic          tx_done;
    logic [15:0]   status_w, reply_w;

    assign shift_en = (state == ST_IDLE && ser_frm_i) || (state == ST_SHIFT);

    sercmd_capture #(.W(W)) u_cap (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
        .frm_bit(ser_frm_i), .adr_bit(ser_adr_i), .dat_bit(ser_dat_i),
        .frame_w(frame_w), .addr_w(addr_w), .data_w(data_w)
    );

    sercmd_decode #(.W(W)) u_dec (
        .frame_w(frame_w), .addr_w(addr_w), .chip_strap(chip_strap), .op(op)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE) begin
                bit_cnt <= CW'(1);
            end else if (state == ST_SHIFT) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (ser_frm_i) nxt = ST_SHIFT;
            ST_SHIFT: if (bit_cnt == CW'(W-1)) nxt = ST_ISSUE;
            ST_ISSUE: nxt = op.rd ? ST_REPLY : ST_IDLE;
            ST_REPLY: if (tx_done) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    assign issue     = (state == ST_ISSUE);
    assign wr_stb    = issue & op.wr;
    assign rd_req    = issue & op.rd;
    assign pll_init  = issue & op.pll;
    assign file_sel  = frame_w[SEL_HI:SEL_LO];
    assign reg_addr  = addr_w[15:0];
    assign reg_wdata = data_w[15:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_o <= 1'b0;
        end else if (wr_stb && file_sel == SEL_LOCAL && reg_addr == 16'd1) begin
            mode_o <= reg_wdata[0];
        end
    end

    assign status_w = {locked_i, align_err_i, 3'b000, mode_o, lock_err_i,
                       bx_err_i, sync_err_i, par_err_i};

    always_comb begin
        if (op.local_rd) begin
            reply_w = (reg_addr == 16'd0) ? status_w : VERSION;
        end else begin
            reply_w = rd_data_i;
        end
    end

    sercmd_reply #(.W(16)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(rd_req), .word(reply_w),
        .frm_o(ser_frm_o), .dat_o(ser_dat_o), .done(tx_done)
    );

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_stb, rd_req, pll_init})); // R3
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb || rd_req || pll_init) |=> !(wr_stb || rd_req || pll_init)); // R3
    AST_CHIP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb || rd_req || pll_init) |-> frame_w[CHIP_HI:CHIP_LO] == chip_strap); // R4
    AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb || rd_req) |-> file_sel < 4'd13); // R5
    AST_INIT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        pll_init |-> (file_sel == SEL_INIT) && !wr_stb); // R6
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && file_sel == SEL_LOCAL && reg_addr == 16'd1) |=> $stable(mode_o)); // R7
    AST_REPLY_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_frm_o) |-> $past(rd_req)); // R10
    AST_REPLY_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> ser_frm_o); // R10
endmodule

// File: tb/tb_sercmd_decoder.sv
module tb_sercmd_decoder;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, frm, adr, dat;
    logic [3:0]  strap;
    logic [15:0] rdata;
    logic [2:0]  perr, serr, berr;
    logic        lerr, aerr, lck;
    logic        wr_stb, rd_req, pll_init, mode_o, ser_frm_o, ser_dat_o;
    logic [3:0]  file_sel;
    logic [15:0] reg_addr, reg_wdata;

    sercmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .ser_frm_i(frm), .ser_adr_i(adr), .ser_dat_i(dat),
        .chip_strap(strap), .rd_data_i(rdata), .par_err_i(perr), .sync_err_i(serr),
        .bx_err_i(berr), .lock_err_i(lerr), .align_err_i(aerr), .locked_i(lck),
        .wr_stb(wr_stb), .rd_req(rd_req), .pll_init(pll_init), .file_sel(file_sel),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .mode_o(mode_o),
        .ser_frm_o(ser_frm_o), .ser_dat_o(ser_dat_o)
    );

    int checks = 0, fails = 0;
    int n_wr, n_rd, n_pll;
    logic [3:0]  s_fs;
    logic [15:0] s_ra, s_wd, rep;
    int rep_len;

    always @(posedge clk) begin
        if (wr_stb) n_wr++;
        if (rd_req) n_rd++;
        if (pll_init) n_pll++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] chip, input logic [3:0] sel, input logic [6:0] low,
                        input logic [15:0] a, input logic [15:0] d);
        logic [15:0] fw;
        fw = {1'b1, chip, sel, low};
        n_wr = 0; n_rd = 0; n_pll = 0;
        for (int i = 0; i < 16; i++) begin
            frm = fw[15-i]; adr = a[15-i]; dat = d[i];
            @(negedge clk);
        end
        frm = 1'b0; adr = 1'b0; dat = 1'b0;
        s_fs = file_sel; s_ra = reg_addr; s_wd = reg_wdata;
        rep = '0; rep_len = 0;
        for (int k = 0; k < 17; k++) begin
            @(negedge clk);
            if (ser_frm_o) begin
                if (rep_len < 16) rep[rep_len] = ser_dat_o;
                rep_len++;
            end
        end
        repeat (2) @(negedge clk);
    endtask

    function automatic logic exp_wr(input int f, input logic [15:0] a);
        return (f <= 2) || f == 6 || (f >= 9 && f <= 12) || (f == 3 && a == 16'd1);
    endfunction
    function automatic logic exp_rd(input int f, input logic [15:0] a);
        return f == 4 || f == 7 || f == 8 || (f == 3 && (a == 16'd0 || a == 16'd2));
    endfunction
    function automatic logic [15:0] exp_status(input logic m);
        return {lck, aerr, 3'b000, m, lerr, berr, serr, perr};
    endfunction

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; frm = 0; adr = 0; dat = 0; strap = 4'h5; rdata = 16'h0;
        perr = 0; serr = 0; berr = 0; lerr = 0; aerr = 0; lck = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 outputs", {wr_stb, rd_req, pll_init, ser_frm_o, ser_dat_o, mode_o}, 0);
        chk("R1 captured", {file_sel, reg_addr, reg_wdata}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R5 R6 R9 R10: every selector with a matching chip field
        for (int f = 0; f < 16; f++) begin
            logic [15:0] a, d;
            a = (f == 3) ? 16'd7 : {f[3:0], 12'hA5C} ^ 16'h0300;
            d = 16'h1234 ^ (16'(f) << 9) ^ 16'(f * 3);
            rdata = 16'hC3A5 ^ 16'(f * 257);
            send(4'h5, f[3:0], 7'(f * 9), a, d);
            chk($sformatf("R3 wr count sel=%0d", f), n_wr, exp_wr(f, a) ? 1 : 0);
            chk($sformatf("R9 rd count sel=%0d", f), n_rd, exp_rd(f, a) ? 1 : 0);
            chk($sformatf("R6 init count sel=%0d", f), n_pll, (f == 5) ? 1 : 0);
            if (exp_wr(f, a)) begin
                chk($sformatf("R2 address sel=%0d", f), s_ra, a);
                chk($sformatf("R2 data sel=%0d", f), s_wd, d);
                chk($sformatf("R3 file_sel sel=%0d", f), s_fs, f);
            end
            if (exp_rd(f, a)) begin
                chk($sformatf("R10 reply length sel=%0d", f), rep_len, 16);
                chk($sformatf("R9 reply word sel=%0d", f), rep, rdata);
            end else begin
                chk($sformatf("R5 no reply sel=%0d", f), rep_len, 0);
            end
        end

        // R4 every non-matching chip field
        for (int c = 0; c < 16; c++) begin
            if (c != 5) begin
                send(c[3:0], 4'd4, 7'h7F, 16'h00FF, 16'hBEEF);
                chk($sformatf("R4 silent chip=%0d", c), n_wr + n_rd + n_pll + rep_len, 0);
            end
        end

        // R7 R8 mode writes and status reads under error-flag patterns
        for (int p = 0; p < 8; p++) begin
            logic m;
            m = p[0];
            {perr, serr, berr} = 9'(p * 73 + 5);
            {lerr, aerr, lck} = p[2:0] ^ 3'b101;
            send(4'h5, 4'd3, 7'h00, 16'd1, m ? 16'h0001 : 16'hFFFE);
            chk("R7 mode write strobe", n_wr, 1);
            chk("R7 mode value", mode_o, m);
            send(4'h5, 4'd3, 7'h2A, 16'd0, 16'hFFFF);
            chk("R8 status length", rep_len, 16);
            chk("R8 status word", rep, exp_status(m));
            chk("R7 mode held after read", mode_o, m);
        end

        // R8 version word
        send(4'h5, 4'd3, 7'h11, 16'd2, 16'h0000);
        chk("R8 version", rep, 16'h0102);
        chk("R10 version length", rep_len, 16);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule